// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the control logic on the device side of a byte-wide parallel NOR flash. It watches write strobes on an 18-bit address bus and an 8-bit data bus. It recognises the multi-write unlock sequences that start a byte program, a whole-array erase, a single-sector erase, identifier mode and the boot-sector lock. While a program or erase runs, a read does not return array data. It returns a status byte instead: one bit flips on every read, and one bit is the complement of the bit being written. A host can therefore poll for completion without a ready pin.

The storage is a small register array whose size is set by parameters. It is split into equal sectors, and the highest-numbered sector is the boot sector. Program and erase take a fixed number of clocks, set by parameters. The output bus is driven only when both chip-enable and output-enable are low.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the block is not busy, identifier mode is off, the lock is clear and every array byte reads FFh.
- R2: `dqOe` is 1 exactly when `ceN` and `oeN` are both 0. Neither `weN` nor the internal state has any effect on it.
- R3: A write is the leading edge of (`ceN`=0, `weN`=0, `oeN`=1). Every command begins with AAh written to 5555h and then 55h written to 2AAAh. Only address bits 14..0 take part in these comparisons.
- R4: Byte program is the unlock pair, then A0h written to 5555h, then one write of the target address and data. The array byte becomes old AND new, so a program only clears bits.
- R5: A write that does not match the step the sequencer expects returns the sequencer to idle. That write is not taken as the start of a new sequence.
- R6: A program keeps the block busy for PROG_CYCLES clocks and an erase for ERASE_CYCLES clocks. During that time a read returns a status byte. Bit 6 flips on every successive read. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bits 5..0 are 0. After completion, reads return array data again with no further command.
- R7: Chip erase is the unlock pair, 80h to 5555h, the unlock pair again, then 10h to 5555h. Every byte becomes FFh, except the boot sector when the lock is set.
- R8: Sector erase uses the same five-write prefix, then 30h written to any address in the target sector. Only that sector becomes FFh. The sector number is address bits [ARRAY_AW-1:SECTOR_AW].
- R9: The unlock pair plus 90h at 5555h enters identifier mode. In identifier mode a read at address bits [1:0] returns: 0 gives MFR_ID, 1 gives DEV_ID, 2 gives FFh if the lock is set and 00h if not, 3 gives 00h. The unlock pair plus F0h at 5555h returns to array reads.
- R10: The five-write erase prefix plus 40h at 5555h keeps the block busy for PROG_CYCLES clocks and then sets the lock. The lock stays set until reset.
- R11: With the lock set, a byte program or sector erase aimed at the boot sector is rejected. Busy is not asserted and the array is unchanged.
- R12: Writes that arrive while the block is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dqOut | output | DATA_W | Read data or status byte |
| dqOe | output | 1 | Output drive enable; the bus is high-impedance when 0 |

## Verification
The bench builds the block with ARRAY_AW=6 and SECTOR_AW=4, which gives 64 bytes in four 16-byte sectors with bytes 48..63 as the boot sector. It uses PROG_CYCLES=6 and ERASE_CYCLES=12. With these values every byte can be programmed twice and read back against an AND model, and a full-array check can follow each erase. An erase lasts long enough for four status reads, so the alternating status bit can be observed several times. The sector split also puts both the locked and the unlocked cases of program, sector erase and chip erase within a short run.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_UNL1, SEQ_UNL2, SEQ_PROG, SEQ_ERA3, SEQ_ERA4, SEQ_ERA5
  } seqState_t;

  typedef enum logic [1:0] {OP_PROG, OP_CHIP, OP_SECT, OP_LOCK} opKind_t;

  typedef struct packed {
    logic latchTgt;
    logic commitProg;
    logic commitChip;
    logic commitSect;
    logic keepBoot;
    logic busy;
    logic idMode;
    logic locked;
    logic progOp;
  } ctrlStrobes_t;

  localparam logic [14:0] CMD_ADDR_A = 15'h5555;
  localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  CODE_UNL1  = 8'hAA;
  localparam logic [7:0]  CODE_UNL2  = 8'h55;
  localparam logic [7:0]  CODE_PROG  = 8'hA0;
  localparam logic [7:0]  CODE_ERASE = 8'h80;
  localparam logic [7:0]  CODE_IDIN  = 8'h90;
  localparam logic [7:0]  CODE_IDOUT = 8'hF0;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;
  localparam logic [7:0]  CODE_SECT  = 8'h30;
  localparam logic [7:0]  CODE_LOCK  = 8'h40;

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int ARRAY_AW     = 8,
  parameter int SECTOR_AW    = 6,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ceN,
  input  logic         oeN,
  input  logic         weN,
  input  logic [14:0]  cmdAddr,
  input  logic [7:0]   din,
  output ctrlStrobes_t strb
);

  localparam int NUM_SECT  = 1 << (ARRAY_AW - SECTOR_AW);
  localparam int BOOT_SECT = NUM_SECT - 1;
  localparam int MAX_CYC   = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seqState_t state, nextState;
  opKind_t   opKind, launchKind;
  logic [CNT_W-1:0] cnt;
  logic busy, locked, idMode;
  logic wrPrev, wrActive, wrEvent;
  logic hitA, hitB, bootHit, launch, setId, clrId, opDone;

  assign wrActive = !ceN && !weN && oeN;
  assign wrEvent  = wrActive && !wrPrev && !busy;
  assign hitA     = (cmdAddr == CMD_ADDR_A);
  assign hitB     = (cmdAddr == CMD_ADDR_B);
  assign bootHit  = (cmdAddr[ARRAY_AW-1:SECTOR_AW] == (ARRAY_AW-SECTOR_AW)'(BOOT_SECT));
  assign opDone   = busy && (cnt == '0);

  always_comb begin
    nextState  = state;
    launch     = 1'b0;
    launchKind = OP_PROG;
    setId      = 1'b0;
    clrId      = 1'b0;
    if (wrEvent) begin
      nextState = SEQ_IDLE;
      unique case (state)
        SEQ_IDLE: if (hitA && din == CODE_UNL1) nextState = SEQ_UNL1;
        SEQ_UNL1: if (hitB && din == CODE_UNL2) nextState = SEQ_UNL2;
        SEQ_UNL2: begin
          if (hitA) begin
            case (din)
              CODE_PROG:  nextState = SEQ_PROG;
              CODE_ERASE: nextState = SEQ_ERA3;
              CODE_IDIN:  setId = 1'b1;
              CODE_IDOUT: clrId = 1'b1;
              default: ;
            endcase
          end
        end
        SEQ_PROG: begin
          if (!(locked && bootHit)) begin
            launch     = 1'b1;
            launchKind = OP_PROG;
          end
        end
        SEQ_ERA3: if (hitA && din == CODE_UNL1) nextState = SEQ_ERA4;
        SEQ_ERA4: if (hitB && din == CODE_UNL2) nextState = SEQ_ERA5;
        SEQ_ERA5: begin
          if (hitA && din == CODE_CHIP) begin
            launch     = 1'b1;
            launchKind = OP_CHIP;
          end else if (din == CODE_SECT && !(locked && bootHit)) begin
            launch     = 1'b1;
            launchKind = OP_SECT;
          end else if (hitA && din == CODE_LOCK) begin
            launch     = 1'b1;
            launchKind = OP_LOCK;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SEQ_IDLE;
      wrPrev <= 1'b0;
      idMode <= 1'b0;
    end else begin
      state  <= nextState;
      wrPrev <= wrActive;
      if (setId) idMode <= 1'b1;
      else if (clrId) idMode <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      opKind <= OP_PROG;
      locked <= 1'b0;
    end else begin
      if (launch) begin
        busy   <= 1'b1;
        opKind <= launchKind;
        cnt    <= (launchKind == OP_CHIP || launchKind == OP_SECT) ?
                  CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
      if (opDone && opKind == OP_LOCK) locked <= 1'b1;
    end
  end

  always_comb begin
    strb.latchTgt   = launch;
    strb.commitProg = opDone && (opKind == OP_PROG);
    strb.commitChip = opDone && (opKind == OP_CHIP);
    strb.commitSect = opDone && (opKind == OP_SECT);
    strb.keepBoot   = locked;
    strb.busy       = busy;
    strb.idMode     = idMode;
    strb.locked     = locked;
    strb.progOp     = (opKind == OP_PROG);
  end

  AST_SEQ_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> state == SEQ_IDLE); // R12
  AST_BOOT_REJECT_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEvent && state == SEQ_PROG && locked && bootHit) |=> !busy); // R11
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked); // R10
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> busy); // R6

endmodule

// File: rtl/nor_cmd_data.sv
module nor_cmd_data
  import nor_cmd_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ARRAY_AW  = 8,
  parameter int SECTOR_AW = 6,
  parameter logic [DATA_W-1:0] MFR_ID = 8'h5A,
  parameter logic [DATA_W-1:0] DEV_ID = 8'hC3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                oeN,
  input  logic [ARRAY_AW-1:0] byteAddr,
  input  logic [DATA_W-1:0]   din,
  input  ctrlStrobes_t        strb,
  output logic [DATA_W-1:0]   dqOut,
  output logic                dqOe
);

  localparam int NUM_BYTES = 1 << ARRAY_AW;
  localparam int SECT_W    = ARRAY_AW - SECTOR_AW;
  localparam int NUM_SECT  = 1 << SECT_W;
  localparam int BOOT_SECT = NUM_SECT - 1;
  localparam int BOOT_BASE = BOOT_SECT << SECTOR_AW;

  logic [DATA_W-1:0]   mem [NUM_BYTES];
  logic [ARRAY_AW-1:0] tgtIdx;
  logic [DATA_W-1:0]   tgtData;
  logic [SECT_W-1:0]   tgtSect;
  logic rdActive, rdPrev, tog;

  assign tgtSect = tgtIdx[ARRAY_AW-1:SECTOR_AW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtIdx  <= '0;
      tgtData <= '1;
    end else if (strb.latchTgt) begin
      tgtIdx  <= byteAddr;
      tgtData <= din;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (!rstN) begin
        mem[i] <= '1;
      end else if ((strb.commitChip &&
                    !(strb.keepBoot && (i >> SECTOR_AW) == BOOT_SECT)) ||
                   (strb.commitSect && (i >> SECTOR_AW) == int'(tgtSect))) begin
        mem[i] <= '1;
      end else if (strb.commitProg && int'(tgtIdx) == i) begin
        mem[i] <= mem[i] & tgtData;
      end
    end
  end

  assign rdActive = !ceN && !oeN;
  assign dqOe     = rdActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev <= 1'b0;
      tog    <= 1'b0;
    end else begin
      rdPrev <= rdActive;
      if (rdPrev && !rdActive && strb.busy) tog <= !tog;
    end
  end

  always_comb begin
    if (strb.busy) begin
      dqOut = {strb.progOp ? !tgtData[DATA_W-1] : 1'b0, tog, {(DATA_W-2){1'b0}}};
    end else if (strb.idMode) begin
      case (byteAddr[1:0])
        2'd0:    dqOut = MFR_ID;
        2'd1:    dqOut = DEV_ID;
        2'd2:    dqOut = strb.locked ? '1 : '0;
        default: dqOut = '0;
      endcase
    end else begin
      dqOut = mem[byteAddr];
    end
  end

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitProg |=> ((mem[tgtIdx] & ~$past(mem[tgtIdx])) == '0)); // R4
  AST_BOOT_KEPT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitChip && strb.keepBoot) |=> $stable(mem[BOOT_BASE])); // R10
  AST_SECT_ERASED: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitSect |=> mem[{tgtSect, {SECTOR_AW{1'b0}}}] == '1); // R8

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 8,
  parameter int ARRAY_AW     = 8,
  parameter int SECTOR_AW    = 6,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64,
  parameter logic [DATA_W-1:0] MFR_ID = 8'h5A,
  parameter logic [DATA_W-1:0] DEV_ID = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  ctrlStrobes_t strb;
  logic unusedAddrHi;

  assign unusedAddrHi = ^addr[ADDR_W-1:15];

  nor_cmd_seq #(
    .ARRAY_AW(ARRAY_AW), .SECTOR_AW(SECTOR_AW),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .cmdAddr(addr[14:0]), .din(din[7:0]), .strb(strb)
  );

  nor_cmd_data #(
    .DATA_W(DATA_W), .ARRAY_AW(ARRAY_AW), .SECTOR_AW(SECTOR_AW),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_data (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN),
    .byteAddr(addr[ARRAY_AW-1:0]), .din(din), .strb(strb),
    .dqOut(dqOut), .dqOe(dqOe)
  );

endmodule

// File: tb/nor_cmd_decoder_bench.sv
`timescale 1ns/1ps
module nor_cmd_decoder_bench;

  localparam int PROG  = 6;
  localparam int ERASE = 12;
  localparam int NB    = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b0, oeN = 1'b1, weN = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dqOut;
  logic        dqOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] expMem [NB];
  logic [7:0] v, v0, v1;

  always #2.5 clk = ~clk;

  nor_cmd_decoder #(
    .ARRAY_AW(6), .SECTOR_AW(4), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE),
    .MFR_ID(8'h5A), .DEV_ID(8'hC3)
  ) u_nor_cmd_decoder (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .din(din), .dqOut(dqOut), .dqOe(dqOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
  endtask

  task automatic rd(input logic [17:0] a, output logic [7:0] r);
    @(negedge clk); addr = a; oeN = 1'b0;
    @(negedge clk); r = dqOut; oeN = 1'b1;
  endtask

  task automatic unlock(input logic [17:0] a1 = 18'h05555, input logic [17:0] a2 = 18'h02AAA);
    wr(a1, 8'hAA); wr(a2, 8'h55);
  endtask

  task automatic progStart(input logic [17:0] a, input logic [7:0] d);
    unlock(); wr(18'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic eraseStart(input logic [17:0] a, input logic [7:0] d);
    unlock(); wr(18'h05555, 8'h80); unlock(); wr(a, d);
  endtask

  task automatic waitIdle();
    repeat (ERASE + 4) @(negedge clk);
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < NB; i++) begin
      rd(18'(i), v);
      chk(req, v, expMem[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) expMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, no busy, no id mode
    chk("R1 dqOe idle", {7'd0, dqOe}, 8'h00);
    checkAll("R1 reset array");

    // R2: output gating over all enable combinations
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); ceN = c[0]; oeN = c[1]; weN = 1'b1;
      @(negedge clk); chk("R2 gating", {7'd0, dqOe}, {7'd0, (c == 0)});
    end
    @(negedge clk); ceN = 1'b0; oeN = 1'b1;

    // R4: program every byte twice, AND model
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < NB; i++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'((i * 37 + 5)) : 8'((i * 91 + 8'h6C));
        progStart(18'(i), pat);
        expMem[i] = expMem[i] & pat;
        repeat (PROG + 2) @(negedge clk);
      end
      checkAll("R4 program sweep");
    end

    // R6: status during program
    progStart(18'd5, 8'h00);
    expMem[5] = 8'h00;
    rd(18'd5, v0); rd(18'd5, v1);
    chk("R6 prog poll bit7", {7'd0, v0[7]}, 8'h01);
    chk("R6 prog low bits", {2'b00, v0[5:0]}, 8'h00);
    chk("R6 prog toggle", {7'd0, v1[6]}, {7'd0, ~v0[6]});
    waitIdle();
    rd(18'd5, v); chk("R6 back to array", v, 8'h00);

    // R12: writes during busy ignored
    progStart(18'd10, 8'h00);
    expMem[10] = 8'h00;
    progStart(18'd11, 8'h00);
    waitIdle();
    rd(18'd11, v); chk("R12 ignored while busy", v, expMem[11]);
    rd(18'd10, v); chk("R12 first program done", v, 8'h00);

    // R5: broken sequence does not program
    wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55); wr(18'h05555, 8'hA0); wr(18'd7, 8'h00);
    rd(18'd7, v); chk("R5 bad addr no busy", v, expMem[7]);
    unlock(); wr(18'h05555, 8'h77); wr(18'h05555, 8'hA0); wr(18'd7, 8'h00);
    rd(18'd7, v); chk("R5 bad code", v, expMem[7]);

    // R3: high address bits are ignored in unlock compare
    unlock(18'h3D555, 18'h1AAAA); wr(18'h25555, 8'hA0); wr(18'h20009, 8'h0F);
    expMem[9] = expMem[9] & 8'h0F;
    waitIdle();
    rd(18'd9, v); chk("R3 masked address", v, expMem[9]);

    // R8: sector erase of sector 1, with status toggling
    eraseStart(18'h00013, 8'h30);
    for (int k = 0; k < 4; k++) begin
      rd(18'h13, v);
      chk("R6 erase poll bit7", {7'd0, v[7]}, 8'h00);
      if (k > 0) chk("R6 erase toggle", {7'd0, v[6]}, {7'd0, ~v0[6]});
      v0 = v;
    end
    waitIdle();
    for (int i = 16; i < 32; i++) expMem[i] = 8'hFF;
    checkAll("R8 sector erase");

    // R9: identifier mode
    unlock(); wr(18'h05555, 8'h90);
    rd(18'd0, v); chk("R9 mfr", v, 8'h5A);
    rd(18'd1, v); chk("R9 dev", v, 8'hC3);
    rd(18'd2, v); chk("R9 lock clear", v, 8'h00);
    rd(18'd3, v); chk("R9 reserved", v, 8'h00);
    unlock(); wr(18'h05555, 8'hF0);
    rd(18'd0, v); chk("R9 exit", v, expMem[0]);

    // R7: unlocked chip erase clears everything
    eraseStart(18'h05555, 8'h10);
    waitIdle();
    for (int i = 0; i < NB; i++) expMem[i] = 8'hFF;
    checkAll("R7 chip erase unlocked");

    progStart(18'd3, 8'h3C);  expMem[3]  = 8'h3C; waitIdle();
    progStart(18'd20, 8'h81); expMem[20] = 8'h81; waitIdle();
    progStart(18'd48, 8'h12); expMem[48] = 8'h12; waitIdle();
    progStart(18'd60, 8'h7E); expMem[60] = 8'h7E; waitIdle();

    // R10: set the lock
    eraseStart(18'h05555, 8'h40);
    rd(18'd0, v); chk("R10 lock busy", {2'b00, v[5:0]}, 8'h00);
    waitIdle();
    unlock(); wr(18'h05555, 8'h90);
    rd(18'd2, v); chk("R10 lock reported", v, 8'hFF);
    unlock(); wr(18'h05555, 8'hF0);

    // R11: boot-targeted program and sector erase rejected
    progStart(18'd48, 8'h00);
    rd(18'd48, v); chk("R11 prog rejected no busy", v, 8'h12);
    eraseStart(18'h00030, 8'h30);
    rd(18'd48, v); chk("R11 erase rejected no busy", v, 8'h12);
    waitIdle();
    rd(18'd60, v); chk("R11 boot intact", v, 8'h7E);
    progStart(18'd21, 8'h0F); expMem[21] = 8'h0F; waitIdle();
    rd(18'd21, v); chk("R11 main still programmable", v, 8'h0F);

    // R7/R10: locked chip erase keeps boot sector
    eraseStart(18'h05555, 8'h10);
    waitIdle();
    for (int i = 0; i < 48; i++) expMem[i] = 8'hFF;
    checkAll("R7 chip erase locked");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule